// File: doc/BRIEF.md
# SPI to Wishbone register bridge

This block is an SPI slave that runs entirely on the serial clock and turns each framed 24-bit SPI transaction into one Wishbone classic master cycle on a 16-bit register bus. The frame carries a direction flag and a 4-bit register number. Two side-band inputs extend the address to six bits, and two more choose the byte lanes. The bus clock is the serial clock itself, so the register bus only advances while the SPI master is clocking.

Each frame has a fixed window of three serial clocks for the register slave to acknowledge. The bridge returns three acknowledge bits on MISO inside the frame. If all three are zero, the cycle was dropped and the master must send the frame again. It may do so without releasing chip select. If chip select stays low after a successful frame, the bridge runs bursts to the same register in 16-bit groups. In a read burst the next word is prefetched. In a write burst each group ends with the top three bits of the word that follows.

Top module: `spi_wb_bridge`

## Requirements
- R1: Wire bit 0 of a frame is the direction (1 = write, 0 = read) and wire bits 1..4 are the register number, MSB first. The bus address is {ext_adr_i, register number} (6 bits), and the byte-lane inputs are captured on the first bit of the frame.
- R2: A read cycle starts on the clock after wire bit 4. Wire bits 5..7 carry the acknowledge bits. Each bit reads 1 from the bit time in which the acknowledge is seen onward, so a slave latency of 0, 1 or 2 clocks gives 111, 011 or 001.
- R3: Wire bits 8..23 of a read return the acknowledged data MSB first, and all zeros when no acknowledge came.
- R4: Wire bits 5..20 of a write carry the data MSB first. The write cycle starts after wire bit 20, and wire bits 21..23 on MISO carry its acknowledge bits with the same pattern as in R2.
- R5: If no acknowledge arrives within the three-clock window, the cycle is withdrawn at the window's last edge, the acknowledge bits read 000, and a write has no effect on the register.
- R6: After a frame that reports 000, a new 24-bit frame may follow at once while chip select stays low, and it is decoded as a fresh frame.
- R7: On a successful read, a 1 on wire bit 8 starts a prefetch read of the same register. Each later 16-bit group returns the prefetched word MSB first, and a 1 in the group's first bit starts the next prefetch.
- R8: A read-burst group whose first bit is 0 still returns its word but starts no read. After it, MISO stays 0 and no bus cycle starts until chip select rises.
- R9: On a successful write, the last 3 bits of the frame are bits 15..13 of the next word. Each following 16-bit group supplies bits 12..0 of that word and then bits 15..13 of the one after it, and the word is written after the group's 13th bit.
- R10: Chip select high at a clock edge drops any open cycle and restarts the frame at bit 0, so a partial write never reaches the bus.
- R11: During reset, the bus strobe and MISO are low.
- R12: lane_sel_i[1] enables data bits 15..8 and lane_sel_i[0] enables bits 7..0, and this selection reaches the bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in, sampled on rising sck |
| miso | output | 1 | Serial data out |
| ext_adr_i | input | 2 | Upper address bits, stable for the frame |
| lane_sel_i | input | 2 | Byte-lane enables, stable for the frame |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable |
| wb_adr_o | output | 6 | Bus register address |
| wb_sel_o | output | 2 | Bus byte-lane selects |
| wb_dat_o | output | 16 | Bus write data |
| wb_dat_i | input | 16 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Single frames are run against a slave model whose acknowledge latency is set between 0 and 3 clocks. The four latencies must give the four distinct acknowledge patterns, and latency 3 must leave the register untouched. Writes through different side-band addresses and byte-lane masks, each read back, tell address extension apart from lane merging. Bursts use a slave register whose value advances on every read, which separates a prefetched word from a repeated one, and a logging register that records the order of burst writes. Frames aborted mid-way and retries with chip select held low show which partial frames reach the bus.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
    // Frame controller modes
    typedef enum logic [1:0] {
        SB_FRAME  = 2'd0,   // decoding a 24-bit frame
        SB_RBURST = 2'd1,   // 16-bit read groups
        SB_WBURST = 2'd2,   // 16-bit write groups
        SB_HALT   = 2'd3    // burst ended, wait for chip select release
    } sb_mode_e;
endpackage

// File: rtl/sbr_wb_cycle.sv
`timescale 1ns/1ps
// Bus cycle engine: opens a classic cycle on start, closes it on
// acknowledge, on withdrawal (drop) or on frame abort (kill).
module sbr_wb_cycle #(
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_adr,
    input  logic [SW-1:0] start_sel,
    input  logic [DW-1:0] start_dat,
    input  logic          drop,
    input  logic          wb_ack_i,
    output logic          cyc_o,
    output logic          we_o,
    output logic [AW-1:0] adr_o,
    output logic [SW-1:0] sel_o,
    output logic [DW-1:0] dat_o,
    output logic          hit_o
);
    typedef struct packed {
        logic          cyc;
        logic          we;
        logic [AW-1:0] adr;
        logic [SW-1:0] sel;
        logic [DW-1:0] dat;
    } cyc_st_t;

    cyc_st_t c_d, c_q;
    logic    hit;

    always_comb begin
        c_d = c_q;
        hit = c_q.cyc & wb_ack_i;
        if (kill) begin
            c_d.cyc = 1'b0;
        end else if (start) begin
            c_d.cyc = 1'b1;
            c_d.we  = start_we;
            c_d.adr = start_adr;
            c_d.sel = start_sel;
            c_d.dat = start_dat;
        end else if (hit || drop) begin
            c_d.cyc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cyc_o = c_q.cyc;
    assign we_o  = c_q.we;
    assign adr_o = c_q.adr;
    assign sel_o = c_q.sel;
    assign dat_o = c_q.dat;
    assign hit_o = hit;

    // R1: an unacknowledged request keeps its address until closed
    a_r1_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cyc && !wb_ack_i && !start && !kill && !drop) |=> (cyc_o && $stable(adr_o)))
        else $error("a_r1_request_held");
endmodule

// File: rtl/sbr_miso_sel.sv
`timescale 1ns/1ps
// Chooses the MISO bit for the current bit time.
module sbr_miso_sel
    import sbr_pkg::*;
#(
    parameter int DW       = 16,
    parameter int ADR_BITS = 4,
    parameter int ACK_BITS = 3,
    parameter int CW       = 5
) (
    input  logic          cs_n,
    input  sb_mode_e      mode,
    input  logic [CW-1:0] cnt,
    input  logic          we,
    input  logic          ok,
    input  logic          hit,
    input  logic [DW-1:0] rdata,
    output logic          miso
);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] K_ADR   = CW'(ADR_BITS);
    localparam logic [CW-1:0] K_RDWIN = CW'(ADR_BITS + ACK_BITS);
    localparam logic [CW-1:0] K_WRST  = CW'(ADR_BITS + DW);
    localparam logic [CW-1:0] K_LAST  = CW'(ADR_BITS + DW + ACK_BITS);
    localparam logic [CW-1:0] K_GLAST = CW'(DW - 1);

    logic [CW-1:0] fr_off, gr_off;
    logic [IW-1:0] fr_idx, gr_idx;

    always_comb begin
        fr_off = K_LAST - cnt;
        gr_off = K_GLAST - cnt;
        fr_idx = fr_off[IW-1:0];
        gr_idx = gr_off[IW-1:0];
        miso   = 1'b0;
        if (!cs_n) begin
            unique case (mode)
                SB_FRAME: begin
                    if (!we) begin
                        if (cnt > K_ADR && cnt <= K_RDWIN) miso = ok | hit;
                        else if (cnt > K_RDWIN)            miso = rdata[fr_idx];
                    end else if (cnt > K_WRST) begin
                        miso = ok | hit;
                    end
                end
                SB_RBURST: miso = rdata[gr_idx];
                default:   miso = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/spi_wb_bridge.sv
`timescale 1ns/1ps
module spi_wb_bridge
    import sbr_pkg::*;
#(
    parameter int DW       = 16,
    parameter int ADR_BITS = 4,
    parameter int EXT_BITS = 2,
    parameter int SEL_BITS = 2,
    parameter int ACK_BITS = 3
) (
    input  logic                         sck,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         mosi,
    output logic                         miso,
    input  logic [EXT_BITS-1:0]          ext_adr_i,
    input  logic [SEL_BITS-1:0]          lane_sel_i,
    output logic                         wb_cyc_o,
    output logic                         wb_stb_o,
    output logic                         wb_we_o,
    output logic [EXT_BITS+ADR_BITS-1:0] wb_adr_o,
    output logic [SEL_BITS-1:0]          wb_sel_o,
    output logic [DW-1:0]                wb_dat_o,
    input  logic [DW-1:0]                wb_dat_i,
    input  logic                         wb_ack_i
);
    localparam int FRAME_LEN = 1 + ADR_BITS + DW + ACK_BITS;
    localparam int CW        = $clog2(FRAME_LEN);
    localparam int AW        = EXT_BITS + ADR_BITS;
    localparam int NW        = ACK_BITS - 1;
    localparam logic [CW-1:0] K_ADR   = CW'(ADR_BITS);
    localparam logic [CW-1:0] K_RDWIN = CW'(ADR_BITS + ACK_BITS);
    localparam logic [CW-1:0] K_BFLAG = CW'(ADR_BITS + ACK_BITS + 1);
    localparam logic [CW-1:0] K_WRST  = CW'(ADR_BITS + DW);
    localparam logic [CW-1:0] K_LAST  = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] K_GLAST = CW'(DW - 1);
    localparam logic [CW-1:0] K_GWR   = CW'(DW - ACK_BITS - 1);

    typedef struct packed {
        sb_mode_e             mode;
        logic [CW-1:0]        cnt;
        logic                 we;
        logic [ADR_BITS-1:0]  adr;
        logic [EXT_BITS-1:0]  ext;
        logic [SEL_BITS-1:0]  sel;
        logic [DW-1:0]        wsh;
        logic [NW-1:0]        nxt;
        logic                 ok;
        logic                 bflag;
        logic [DW-1:0]        rdata;
        logic [DW-1:0]        pref;
    } br_st_t;

    br_st_t        s_d, s_q;
    logic          start, start_we, drop, hit;
    logic [DW-1:0] start_dat;
    logic [CW-1:0] k;

    always_comb begin
        s_d       = s_q;
        start     = 1'b0;
        start_we  = 1'b0;
        start_dat = '0;
        drop      = 1'b0;
        k         = s_q.cnt;
        if (cs_n) begin
            s_d.mode  = SB_FRAME;
            s_d.cnt   = '0;
            s_d.ok    = 1'b0;
            s_d.bflag = 1'b0;
        end else begin
            unique case (s_q.mode)
                SB_FRAME: begin
                    s_d.cnt = (k == K_LAST) ? '0 : k + 1'b1;
                    if (k == '0) begin
                        s_d.we    = mosi;
                        s_d.ext   = ext_adr_i;
                        s_d.sel   = lane_sel_i;
                        s_d.ok    = 1'b0;
                        s_d.bflag = 1'b0;
                        s_d.rdata = '0;
                    end else if (k <= K_ADR) begin
                        s_d.adr = {s_q.adr[ADR_BITS-2:0], mosi};
                    end
                    if (!s_q.we) begin
                        if (k == K_ADR) start = 1'b1;
                        if (k > K_ADR && k <= K_RDWIN && hit) begin
                            s_d.ok    = 1'b1;
                            s_d.rdata = wb_dat_i;
                        end
                        if (k == K_RDWIN && !hit) drop = 1'b1;
                        if (k == K_BFLAG) begin
                            s_d.bflag = mosi;
                            if (mosi && s_q.ok) start = 1'b1;
                        end
                        if (k > K_BFLAG && hit) s_d.pref = wb_dat_i;
                        if (k == K_LAST && s_q.ok && s_q.bflag) begin
                            s_d.mode  = SB_RBURST;
                            s_d.rdata = hit ? wb_dat_i : s_q.pref;
                        end
                    end else begin
                        if (k > K_ADR && k <= K_WRST) s_d.wsh = {s_q.wsh[DW-2:0], mosi};
                        if (k == K_WRST) begin
                            start     = 1'b1;
                            start_we  = 1'b1;
                            start_dat = {s_q.wsh[DW-2:0], mosi};
                        end
                        if (k > K_WRST) begin
                            s_d.nxt = NW'({s_q.nxt, mosi});
                            if (hit) s_d.ok = 1'b1;
                        end
                        if (k == K_LAST) begin
                            if (!hit) drop = 1'b1;
                            if (s_q.ok || hit) begin
                                s_d.mode = SB_WBURST;
                                s_d.wsh  = DW'({s_q.nxt, mosi});
                            end
                        end
                    end
                end
                SB_RBURST: begin
                    s_d.cnt = (k == K_GLAST) ? '0 : k + 1'b1;
                    if (hit) s_d.pref = wb_dat_i;
                    if (k == '0) begin
                        s_d.bflag = mosi;
                        if (mosi) start = 1'b1;
                    end
                    if (k == K_GLAST) begin
                        s_d.rdata = hit ? wb_dat_i : s_q.pref;
                        s_d.mode  = s_q.bflag ? SB_RBURST : SB_HALT;
                    end
                end
                SB_WBURST: begin
                    s_d.cnt = (k == K_GLAST) ? '0 : k + 1'b1;
                    if (k <= K_GWR) s_d.wsh = {s_q.wsh[DW-2:0], mosi};
                    if (k == K_GWR) begin
                        start     = 1'b1;
                        start_we  = 1'b1;
                        start_dat = {s_q.wsh[DW-2:0], mosi};
                    end
                    if (k > K_GWR) s_d.nxt = NW'({s_q.nxt, mosi});
                    if (k == K_GLAST) s_d.wsh = DW'({s_q.nxt, mosi});
                end
                default: s_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    sbr_wb_cycle #(.DW(DW), .AW(AW), .SW(SEL_BITS)) u_cyc (
        .clk       (sck),
        .rst_n     (rst_n),
        .kill      (cs_n),
        .start     (start),
        .start_we  (start_we),
        .start_adr ({s_q.ext, s_d.adr}),
        .start_sel (s_q.sel),
        .start_dat (start_dat),
        .drop      (drop),
        .wb_ack_i  (wb_ack_i),
        .cyc_o     (wb_cyc_o),
        .we_o      (wb_we_o),
        .adr_o     (wb_adr_o),
        .sel_o     (wb_sel_o),
        .dat_o     (wb_dat_o),
        .hit_o     (hit)
    );

    assign wb_stb_o = wb_cyc_o;

    sbr_miso_sel #(.DW(DW), .ADR_BITS(ADR_BITS), .ACK_BITS(ACK_BITS), .CW(CW)) u_miso (
        .cs_n  (cs_n),
        .mode  (s_q.mode),
        .cnt   (s_q.cnt),
        .we    (s_q.we),
        .ok    (s_q.ok),
        .hit   (hit),
        .rdata (s_q.rdata),
        .miso  (miso)
    );

    // R2: once a read acknowledge shows on MISO it stays for the window
    a_r2_ack_sticky: assert property (@(posedge sck) disable iff (!rst_n)
        (!cs_n && s_q.mode == SB_FRAME && !s_q.we && s_q.cnt > K_ADR
         && s_q.cnt < K_RDWIN && miso) |=> miso)
        else $error("a_r2_ack_sticky");

    // R5: a read still unacknowledged at the window's last edge is withdrawn
    a_r5_read_withdrawn: assert property (@(posedge sck) disable iff (!rst_n)
        (!cs_n && s_q.mode == SB_FRAME && !s_q.we && s_q.cnt == K_RDWIN
         && wb_cyc_o && !wb_ack_i) |=> !wb_cyc_o)
        else $error("a_r5_read_withdrawn");

    // R5: same for a write at the end of the frame
    a_r5_write_withdrawn: assert property (@(posedge sck) disable iff (!rst_n)
        (!cs_n && s_q.mode == SB_FRAME && s_q.we && s_q.cnt == K_LAST
         && wb_cyc_o && !wb_ack_i) |=> !wb_cyc_o)
        else $error("a_r5_write_withdrawn");

    // R8: after a read burst ends, MISO stays low
    a_r8_halt_quiet: assert property (@(posedge sck) disable iff (!rst_n)
        (!cs_n && s_q.mode == SB_HALT) |-> !miso)
        else $error("a_r8_halt_quiet");

    // R10: chip select high closes any open cycle
    a_r10_abort_drops: assert property (@(posedge sck) disable iff (!rst_n)
        cs_n |=> !wb_cyc_o)
        else $error("a_r10_abort_drops");
endmodule

// File: tb/spi_wb_bridge_test.sv
`timescale 1ns/1ps
module spi_wb_bridge_test;
    logic        sck = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [1:0]  ext_adr = 2'd0;
    logic [1:0]  lane_sel = 2'b11;
    logic        cyc, stb, we, ack;
    logic [5:0]  adr;
    logic [1:0]  sel;
    logic [15:0] dout, din;

    int checks = 0;
    int errors = 0;

    always #10 sck = ~sck;   // 50 MHz

    spi_wb_bridge uut (
        .sck(sck), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .ext_adr_i(ext_adr), .lane_sel_i(lane_sel),
        .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_adr_o(adr),
        .wb_sel_o(sel), .wb_dat_o(dout), .wb_dat_i(din), .wb_ack_i(ack)
    );

    // Slave model: latency-programmable acknowledge, 64 registers,
    // register 63 counts up on each read, register 62 logs writes.
    logic [1:0]  lat = 2'd0;
    logic [2:0]  wcnt = 3'd0;
    logic [15:0] mem [64];
    logic [15:0] ctr = 16'h0100;
    logic [15:0] wlog [4];
    int          wlog_n = 0;

    assign ack = stb && (wcnt == {1'b0, lat});
    assign din = (adr == 6'd63) ? ctr : mem[adr];

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        for (int i = 0; i < 4; i++) wlog[i] = 16'h0000;
    end

    always @(posedge sck) begin
        if (stb && !ack) wcnt <= wcnt + 3'd1;
        else             wcnt <= 3'd0;
        if (stb && ack) begin
            if (we) begin
                if (adr == 6'd62) begin
                    if (wlog_n < 4) wlog[wlog_n] <= dout;
                    wlog_n <= wlog_n + 1;
                end else begin
                    if (sel[1]) mem[adr][15:8] <= dout[15:8];
                    if (sel[0]) mem[adr][7:0]  <= dout[7:0];
                end
            end else if (adr == 6'd63) begin
                ctr <= ctr + 16'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic m);
        @(negedge sck);
        m    = miso;
        cs_n = 1'b0;
        mosi = b;
    endtask

    task automatic release_cs();
        @(negedge sck);
        cs_n = 1'b1;
        mosi = 1'b0;
        @(negedge sck);
    endtask

    task automatic frame24(input logic [23:0] tx, output logic [23:0] rx);
        for (int i = 23; i >= 0; i--) bit_io(tx[i], rx[i]);
    endtask

    task automatic group16(input logic [15:0] tx, output logic [15:0] rx);
        for (int i = 15; i >= 0; i--) bit_io(tx[i], rx[i]);
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  ext;
        logic [3:0]  reg_n;
        logic [1:0]  lanes;
        logic [15:0] dat;
        logic [1:0]  lat;
        logic [2:0]  xack;
        logic [15:0] xrd;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd1, 4'h3, 2'b11, 16'hA5C3, 2'd0, 3'b111, 16'h0000}, // R4 lat 0
        '{1'b0, 2'd1, 4'h3, 2'b11, 16'h0000, 2'd1, 3'b011, 16'hA5C3}, // R2 lat 1
        '{1'b1, 2'd0, 4'h3, 2'b11, 16'h5A3C, 2'd2, 3'b001, 16'h0000}, // R4 lat 2
        '{1'b0, 2'd0, 4'h3, 2'b11, 16'h0000, 2'd0, 3'b111, 16'h5A3C}, // R1 ext 0
        '{1'b0, 2'd1, 4'h3, 2'b11, 16'h0000, 2'd2, 3'b001, 16'hA5C3}, // R1 ext 1 kept apart
        '{1'b1, 2'd1, 4'h3, 2'b01, 16'h1177, 2'd1, 3'b011, 16'h0000}, // R12 low lane
        '{1'b0, 2'd1, 4'h3, 2'b11, 16'h0000, 2'd0, 3'b111, 16'hA577}, // R12
        '{1'b1, 2'd1, 4'h3, 2'b10, 16'h8800, 2'd0, 3'b111, 16'h0000}, // R12 high lane
        '{1'b0, 2'd1, 4'h3, 2'b11, 16'h0000, 2'd0, 3'b111, 16'h8877}, // R12
        '{1'b1, 2'd2, 4'hF, 2'b11, 16'hFFFF, 2'd3, 3'b000, 16'h0000}, // R5 late write
        '{1'b0, 2'd2, 4'hF, 2'b11, 16'h0000, 2'd0, 3'b111, 16'h0000}, // R5 not written
        '{1'b0, 2'd1, 4'h3, 2'b11, 16'h0000, 2'd3, 3'b000, 16'h0000}  // R5 R3 late read
    };

    task automatic do_read(input logic [3:0] r, input logic b,
                           output logic [2:0] a, output logic [15:0] d);
        logic [23:0] rx;
        frame24({1'b0, r, 3'b000, b, 15'h0000}, rx);
        a = rx[18:16];
        d = rx[15:0];
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] rx;
        logic [15:0] g;
        logic [2:0]  a;
        logic [15:0] d;
        logic [15:0] w1, w2;

        // R11: reset state
        repeat (3) @(negedge sck);
        chk("R11 stb in reset", {31'd0, stb}, 32'd0);
        chk("R11 miso in reset", {31'd0, miso}, 32'd0);
        @(negedge sck);
        rst_n = 1'b1;
        @(negedge sck);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            ext_adr  = VEC[v].ext;
            lane_sel = VEC[v].lanes;
            lat      = VEC[v].lat;
            if (VEC[v].wr) begin
                frame24({1'b1, VEC[v].reg_n, VEC[v].dat, 3'b000}, rx);
                chk(VEC[v].lat == 2'd3 ? "R5 write ack" : "R4 write ack",
                    {29'd0, rx[2:0]}, {29'd0, VEC[v].xack});
            end else begin
                do_read(VEC[v].reg_n, 1'b0, a, d);
                chk(VEC[v].lat == 2'd3 ? "R5 read ack" : "R2 read ack",
                    {29'd0, a}, {29'd0, VEC[v].xack});
                chk("R3 read data", {16'd0, d}, {16'd0, VEC[v].xrd});
            end
            release_cs();
        end

        // R1: address and direction on the bus, then R10 abort of open read
        ext_adr = 2'd2; lane_sel = 2'b11; lat = 2'd3;
        for (int i = 23; i >= 17; i--) bit_io(((24'h0F0000 | 24'h780000) >> i) & 1, rx[i]);
        @(negedge sck);
        chk("R1 bus address", {26'd0, adr}, {26'd0, 6'h2F});
        chk("R1 read direction", {31'd0, we}, 32'd0);
        cs_n = 1'b1;
        @(negedge sck);
        chk("R10 cycle dropped", {31'd0, stb}, 32'd0);
        @(negedge sck);

        // R10: partial write is discarded
        ext_adr = 2'd1; lat = 2'd0;
        for (int i = 23; i >= 14; i--) bit_io((({1'b1, 4'h3, 16'h0000, 3'b000}) >> i) & 1, rx[i]);
        release_cs();
        do_read(4'h3, 1'b0, a, d);
        chk("R10 register unchanged", {16'd0, d}, {16'd0, 16'h8877});
        release_cs();

        // R6: retry with chip select held low
        ext_adr = 2'd0; lat = 2'd3;
        frame24({1'b1, 4'h5, 16'h6E21, 3'b000}, rx);
        chk("R6 first try fails", {29'd0, rx[2:0]}, 32'd0);
        lat = 2'd0;
        frame24({1'b1, 4'h5, 16'h6E21, 3'b000}, rx);
        chk("R6 retry acked", {29'd0, rx[2:0]}, {29'd0, 3'b111});
        release_cs();
        do_read(4'h5, 1'b0, a, d);
        chk("R6 retry data", {16'd0, d}, {16'd0, 16'h6E21});
        release_cs();

        // R7/R8: read burst on the counting register 63
        ext_adr = 2'd3; lat = 2'd2;
        do_read(4'hF, 1'b1, a, d);
        chk("R7 burst first ack", {29'd0, a}, {29'd0, 3'b001});
        chk("R7 burst word 0", {16'd0, d}, {16'd0, 16'h0100});
        group16(16'h8000, g);
        chk("R7 burst word 1", {16'd0, g}, {16'd0, 16'h0101});
        group16(16'h0000, g);
        chk("R8 last word returned", {16'd0, g}, {16'd0, 16'h0102});
        group16(16'h8000, g);
        chk("R8 miso quiet after burst", {16'd0, g}, 32'd0);
        release_cs();
        do_read(4'hF, 1'b0, a, d);
        chk("R8 no extra reads", {16'd0, d}, {16'd0, 16'h0103});
        release_cs();

        // R9: write burst on the logging register 62
        w1 = 16'hBEEF; w2 = 16'h0F0F;
        frame24({1'b1, 4'hE, 16'h1234, w1[15:13]}, rx);
        chk("R9 burst first ack", {29'd0, rx[2:0]}, {29'd0, 3'b001});
        group16({w1[12:0], w2[15:13]}, g);
        group16({w2[12:0], 3'b000}, g);
        release_cs();
        chk("R9 write count", wlog_n, 32'd3);
        chk("R9 word 0", {16'd0, wlog[0]}, {16'd0, 16'h1234});
        chk("R9 word 1", {16'd0, wlog[1]}, {16'd0, w1});
        chk("R9 word 2", {16'd0, wlog[2]}, {16'd0, w2});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule